// File: doc/BRIEF.md
# Pseudo-SRAM Ferroelectric Memory Target Model

This block is a clocked, synthesizable model of the memory side of an asynchronous pseudo-SRAM style interface. A fast sample clock observes two chip selects, a write strobe and a read strobe. The block works out when the device leaves its quiet state and starts an access. That start can come from a select edge, a write-strobe fall or a read-strobe fall. The block captures the address, and for writes the data, on that edge, and stores bytes in an array whose depth is a parameter. A read drives the stored byte onto the output bus after a configurable number of sample clocks. The bus is released when the access ends.

Between two accesses the interface must return to its quiet (precharge) state for a minimum time. The block measures this time, the start-to-start cycle time and the active time in sample clocks. Any shortfall raises a sticky error flag. An access whose start breaks the precharge or cycle-time rule is rejected: nothing is written and the bus is not driven. The block serves as a self-contained target when verifying a memory controller.

Top module: `pseudo_sram_fram_model`

## Requirements
- R1: The device is quiet when `sel_a_n` is high, or `sel_b` is low, or both `wr_n` and `rd_n` are high. Whenever it is quiet, `bus_drive` is low once the release latency of R7 has passed, and write attempts leave the array unchanged. Reset clears `bus_drive` and all three error flags.
- R2: If `sel_a_n` falls while `sel_b` is high, `wr_n` is high and `rd_n` is low, a read of the address present at that edge starts.
- R3: If `sel_b` rises while `sel_a_n` is low, `wr_n` is high and `rd_n` is low, a read of the address present at that edge starts.
- R4: If `rd_n` falls while both selects are active and `wr_n` is high, a read starts. The address is taken at that edge, and later changes of `mem_addr` during the access do not alter the byte returned.
- R5: If `wr_n` falls while both selects are active, the address and data present at that edge are written. Later changes of `mem_addr` or `bus_in` during the access do not alter what is stored, and no other location changes.
- R6: If a select edge makes the device active while `wr_n` is already low and `rd_n` is high, the address and data present at that edge are written.
- R7: Let edge 1 be the first rising clock edge that samples the pin change starting a read. `bus_drive` rises on edge IN_STAGES + ACCESS_LAT + 1, and `bus_out` then holds the stored byte. Let edge 1 be the first rising edge that samples the pin change ending the access. `bus_drive` falls on edge IN_STAGES + 1.
- R8: An access starts after fewer than PRE_MIN quiet samples since the previous access ended. In that case `err_precharge` is set, the access is rejected (no write, no bus drive), and the stored data is unchanged. Exactly PRE_MIN quiet samples is legal, and the first access after reset is never checked.
- R9: An access starts fewer than CYC_MIN sample clocks after the previous access start. In that case `err_cycle` is set and the access is rejected as in R8.
- R10: An access ends after fewer than ACT_MIN active samples. In that case `err_active` is set, but the access itself is still carried out. Exactly ACT_MIN samples is legal.
- R11: The three error flags stay set through later legal accesses, and only the synchronous reset `rst` clears them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_a_n | input | 1 | Primary chip select, active low |
| sel_b | input | 1 | Secondary chip select, active high |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read (output) strobe, active low |
| mem_addr | input | ADDR_W | Byte address |
| bus_in | input | DATA_W | Write data from the controller |
| bus_out | output | DATA_W | Read data, valid while bus_drive is high |
| bus_drive | output | 1 | Bus output enable; low means high impedance |
| err_precharge | output | 1 | Sticky flag for a precharge time shortfall |
| err_cycle | output | 1 | Sticky flag for a cycle time shortfall |
| err_active | output | 1 | Sticky flag for an active time shortfall |

## Verification
The bench builds the block with one input stage, ACCESS_LAT = 3, PRE_MIN = 2, CYC_MIN = 8 and ACT_MIN = 4. With these limits, accesses a few clocks long land exactly on each limit or one sample short of it. So the legal boundary and the violating case of every timing rule are reached, and rejected writes are compared against earlier stored bytes. The short latency also lets the bench check the first and last driving edge of every read for each of the three kinds of start edge.

// File: rtl/fram_emu_pkg.sv
package fram_emu_pkg;

   typedef struct packed {
      logic sel_a_n;
      logic sel_b;
      logic wr_n;
      logic rd_n;
   } pin_ctl_t;

   localparam pin_ctl_t CTL_QUIET = '{sel_a_n: 1'b1, sel_b: 1'b0, wr_n: 1'b1, rd_n: 1'b1};

   // True when both selects are active and at least one strobe is low.
   function automatic logic is_engaged(pin_ctl_t c);
      return !c.sel_a_n && c.sel_b && !(c.wr_n && c.rd_n);
   endfunction

endpackage

// File: rtl/fram_pin_sampler.sv
module fram_pin_sampler
   import fram_emu_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 8,
   parameter int IN_STAGES = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  pin_ctl_t          ctl_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              eng_o,
   output logic              start_o,
   output logic              finish_o,
   output logic              start_wr_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] data_o
);

   localparam int CTL_W = $bits(pin_ctl_t);
   localparam int SW    = CTL_W + ADDR_W + DATA_W;
   localparam logic [SW-1:0] STAGE_RST = {CTL_QUIET, {ADDR_W{1'b0}}, {DATA_W{1'b0}}};

   generate
      if (IN_STAGES < 1 || IN_STAGES > 3) begin : g_bad_stages
         $error("fram_pin_sampler: IN_STAGES must be 1..3");
      end
   endgenerate

   logic [SW-1:0] pin_vec;
   logic [SW-1:0] stage_q [IN_STAGES];
   pin_ctl_t      cur_ctl;
   logic          eng_prev;

   assign pin_vec = {ctl_i, addr_i, data_i};

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < IN_STAGES; i++) stage_q[i] <= STAGE_RST;
      end else begin
         stage_q[0] <= pin_vec;
         for (int i = 1; i < IN_STAGES; i++) stage_q[i] <= stage_q[i-1];
      end
   end

   assign {cur_ctl, addr_o, data_o} = stage_q[IN_STAGES-1];

   assign eng_o = is_engaged(cur_ctl);

   always_ff @(posedge clk) begin
      if (rst) eng_prev <= 1'b0;
      else     eng_prev <= eng_o;
   end

   assign start_o    = eng_o && !eng_prev;
   assign finish_o   = !eng_o && eng_prev;
   assign start_wr_o = start_o && !cur_ctl.wr_n;

endmodule

// File: rtl/fram_span_counter.sv
module fram_span_counter #(
   parameter int LIMIT = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic restart,
   input  logic seed,
   output logic short_o
);

   generate
      if (LIMIT < 0) begin : g_bad_limit
         $error("fram_span_counter: LIMIT must not be negative");
      end
      if (LIMIT == 0) begin : g_off
         logic unused_inputs;
         assign unused_inputs = ^{clk, rst, restart, seed};
         assign short_o = 1'b0;
      end else begin : g_on
         localparam int CW = $clog2(LIMIT + 1);
         localparam logic [CW-1:0] CAP = CW'(LIMIT);
         localparam logic [CW-1:0] ONE = CW'(1);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk) begin
            if (rst)              cnt <= '0;
            else if (restart)     cnt <= seed ? ONE : '0;
            else if (cnt != CAP)  cnt <= cnt + ONE;
         end

         assign short_o = (cnt < CAP);
      end
   endgenerate

endmodule

// File: rtl/fram_access_guard.sv
module fram_access_guard #(
   parameter int PRE_MIN = 2,
   parameter int CYC_MIN = 15,
   parameter int ACT_MIN = 12
) (
   input  logic clk,
   input  logic rst,
   input  logic eng,
   input  logic start,
   input  logic finish,
   output logic reject,
   output logic err_pre,
   output logic err_cyc,
   output logic err_act
);

   logic pre_short, cyc_short, act_short;
   logic seen_q;
   logic pre_bad, cyc_bad;

   // quiet samples since the last access ended
   fram_span_counter #(.LIMIT(PRE_MIN)) i_pre_span (
      .clk(clk), .rst(rst), .restart(eng), .seed(1'b0), .short_o(pre_short));

   // samples since the last access start
   fram_span_counter #(.LIMIT(CYC_MIN)) i_cyc_span (
      .clk(clk), .rst(rst), .restart(start), .seed(1'b1), .short_o(cyc_short));

   // samples the current access has been active
   fram_span_counter #(.LIMIT(ACT_MIN)) i_act_span (
      .clk(clk), .rst(rst), .restart(!eng), .seed(1'b0), .short_o(act_short));

   assign pre_bad = start && seen_q && pre_short;
   assign cyc_bad = start && seen_q && cyc_short;
   assign reject  = pre_bad || cyc_bad;

   always_ff @(posedge clk) begin
      if (rst) begin
         seen_q  <= 1'b0;
         err_pre <= 1'b0;
         err_cyc <= 1'b0;
         err_act <= 1'b0;
      end else begin
         if (start) seen_q <= 1'b1;
         if (pre_bad) err_pre <= 1'b1;
         if (cyc_bad) err_cyc <= 1'b1;
         if (finish && act_short) err_act <= 1'b1;
      end
   end

   AST_PRE_FLAG_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $rose(err_pre)) |-> $past(start)); // R8
   AST_CYC_FLAG_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $rose(err_cyc)) |-> $past(start)); // R9
   AST_ACT_FLAG_NEEDS_END: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $rose(err_act)) |-> $past(finish)); // R10
   AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && ($past(err_pre) || $past(err_cyc) || $past(err_act)))
      |-> ((err_pre || !$past(err_pre)) && (err_cyc || !$past(err_cyc))
           && (err_act || !$past(err_act)))); // R11

endmodule

// File: rtl/fram_cell_array.sv
module fram_cell_array #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter int DEPTH  = 256
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("fram_cell_array: DEPTH must be a power of two >= 2");
      end
      if (IDX_W > ADDR_W) begin : g_bad_width
         $error("fram_cell_array: DEPTH exceeds the address range");
      end
      if (DEPTH > 4096) begin : g_too_big
         $error("fram_cell_array: DEPTH above 4096 not supported");
      end
   endgenerate

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) cells[wr_addr[IDX_W-1:0]] <= wr_data;
   end

   assign rd_data = cells[rd_addr[IDX_W-1:0]];

endmodule

// File: rtl/fram_read_driver.sv
module fram_read_driver #(
   parameter int DATA_W     = 8,
   parameter int ACCESS_LAT = 12
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              eng,
   input  logic              rd_start,
   input  logic [DATA_W-1:0] cell_data,
   output logic              drive_o,
   output logic [DATA_W-1:0] data_o
);

   localparam int WW = (ACCESS_LAT > 1) ? $clog2(ACCESS_LAT) : 1;
   localparam logic [WW-1:0] WAIT_LOAD = WW'(ACCESS_LAT - 1);

   generate
      if (ACCESS_LAT < 1) begin : g_bad_lat
         $error("fram_read_driver: ACCESS_LAT must be at least 1");
      end
   endgenerate

   logic          pending;
   logic [WW-1:0] wait_cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         pending  <= 1'b0;
         wait_cnt <= '0;
         drive_o  <= 1'b0;
         data_o   <= '0;
      end else if (rd_start) begin
         pending  <= 1'b1;
         wait_cnt <= WAIT_LOAD;
      end else if (!eng) begin
         pending  <= 1'b0;
         drive_o  <= 1'b0;
         data_o   <= '0;
      end else if (pending) begin
         if (wait_cnt == '0) begin
            pending <= 1'b0;
            drive_o <= 1'b1;
            data_o  <= cell_data;
         end else begin
            wait_cnt <= wait_cnt - 1'b1;
         end
      end
   end

   AST_RELEASE_AFTER_END: assert property (@(posedge clk) disable iff (rst)
      !eng |=> !drive_o); // R7

endmodule

// File: rtl/pseudo_sram_fram_model.sv
module pseudo_sram_fram_model
   import fram_emu_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 8,
   parameter int DEPTH      = 256,
   parameter int IN_STAGES  = 1,
   parameter int ACCESS_LAT = 12,
   parameter int PRE_MIN    = 2,
   parameter int CYC_MIN    = 15,
   parameter int ACT_MIN    = 12
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sel_a_n,
   input  logic              sel_b,
   input  logic              wr_n,
   input  logic              rd_n,
   input  logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] bus_in,
   output logic [DATA_W-1:0] bus_out,
   output logic              bus_drive,
   output logic              err_precharge,
   output logic              err_cycle,
   output logic              err_active
);

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_widths
         $error("pseudo_sram_fram_model: widths must be positive");
      end
      if (CYC_MIN < 0 || ACT_MIN < 0 || PRE_MIN < 0) begin : g_bad_limits
         $error("pseudo_sram_fram_model: timing limits must not be negative");
      end
   endgenerate

   pin_ctl_t          ctl_pins;
   logic              eng, start, finish, start_wr;
   logic [ADDR_W-1:0] smp_addr;
   logic [DATA_W-1:0] smp_data;
   logic              reject;
   logic              wr_en, rd_start;
   logic [ADDR_W-1:0] lat_addr;
   logic [DATA_W-1:0] cell_data;

   assign ctl_pins.sel_a_n = sel_a_n;
   assign ctl_pins.sel_b   = sel_b;
   assign ctl_pins.wr_n    = wr_n;
   assign ctl_pins.rd_n    = rd_n;

   fram_pin_sampler #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IN_STAGES(IN_STAGES)
   ) i_sampler (
      .clk(clk), .rst(rst), .ctl_i(ctl_pins), .addr_i(mem_addr), .data_i(bus_in),
      .eng_o(eng), .start_o(start), .finish_o(finish), .start_wr_o(start_wr),
      .addr_o(smp_addr), .data_o(smp_data));

   fram_access_guard #(
      .PRE_MIN(PRE_MIN), .CYC_MIN(CYC_MIN), .ACT_MIN(ACT_MIN)
   ) i_guard (
      .clk(clk), .rst(rst), .eng(eng), .start(start), .finish(finish),
      .reject(reject), .err_pre(err_precharge), .err_cyc(err_cycle),
      .err_act(err_active));

   assign wr_en    = start_wr && !reject;
   assign rd_start = start && !start_wr && !reject;

   // read address held from the starting edge to the drive point
   always_ff @(posedge clk) begin
      if (rst)           lat_addr <= '0;
      else if (rd_start) lat_addr <= smp_addr;
   end

   fram_cell_array #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)
   ) i_cells (
      .clk(clk), .wr_en(wr_en), .wr_addr(smp_addr), .wr_data(smp_data),
      .rd_addr(lat_addr), .rd_data(cell_data));

   fram_read_driver #(
      .DATA_W(DATA_W), .ACCESS_LAT(ACCESS_LAT)
   ) i_reader (
      .clk(clk), .rst(rst), .eng(eng), .rd_start(rd_start),
      .cell_data(cell_data), .drive_o(bus_drive), .data_o(bus_out));

   AST_BUS_NEEDS_ENGAGE: assert property (@(posedge clk) disable iff (rst)
      bus_drive |-> $past(eng)); // R1

endmodule

// File: tb/test_pseudo_sram_fram_model.sv
module test_pseudo_sram_fram_model;

   localparam int CLK_PERIOD = 10;
   localparam int LAT        = 3;
   localparam int ACT_RD     = 6;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       sel_a_n = 1'b0, sel_b = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
   logic [7:0] mem_addr = '0, bus_in = '0;
   logic [7:0] bus_out;
   logic       bus_drive, err_precharge, err_cycle, err_active;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pseudo_sram_fram_model #(
      .ADDR_W(8), .DATA_W(8), .DEPTH(256), .IN_STAGES(1), .ACCESS_LAT(LAT),
      .PRE_MIN(2), .CYC_MIN(8), .ACT_MIN(4)
   ) i_pseudo_sram_fram_model (
      .clk(clk), .rst(rst), .sel_a_n(sel_a_n), .sel_b(sel_b), .wr_n(wr_n),
      .rd_n(rd_n), .mem_addr(mem_addr), .bus_in(bus_in), .bus_out(bus_out),
      .bus_drive(bus_drive), .err_precharge(err_precharge),
      .err_cycle(err_cycle), .err_active(err_active));

   task automatic check(bit ok, string tag, int act, int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic drive(logic an, logic b, logic w, logic r, logic [7:0] a, logic [7:0] d);
      sel_a_n = an; sel_b = b; wr_n = w; rd_n = r; mem_addr = a; bus_in = d;
   endtask

   task automatic check_flags(logic p, logic c, logic a, string tag);
      check(err_precharge == p, {tag, " err_precharge"}, err_precharge, p);
      check(err_cycle == c,     {tag, " err_cycle"},     err_cycle, c);
      check(err_active == a,    {tag, " err_active"},    err_active, a);
   endtask

   // kind 0: write strobe fall, kind 1: primary select fall
   task automatic do_write(int kind, logic [7:0] a, logic [7:0] d, int act, int idle, bit scramble);
      if (kind == 1) begin drive(1, 1, 0, 1, a, d); @(negedge clk); end
      drive(0, 1, 0, 1, a, d);
      if (scramble) begin
         @(negedge clk);
         mem_addr = a ^ 8'h01;
         bus_in   = ~d;
         repeat (act - 1) @(negedge clk);
      end else begin
         repeat (act) @(negedge clk);
      end
      drive(0, 1, 1, 1, a, d);
      repeat (idle) @(negedge clk);
   endtask

   // kind 0: read strobe fall, kind 1: primary select fall, kind 2: secondary select rise
   task automatic do_read(int kind, logic [7:0] a, logic [7:0] exp, string tag, bit expect_drive);
      if (kind == 1) begin drive(1, 1, 1, 0, a, 8'h00); @(negedge clk); end
      else if (kind == 2) begin drive(0, 0, 1, 0, a, 8'h00); @(negedge clk); end
      drive(0, 1, 1, 0, a, 8'h00);
      @(negedge clk);
      mem_addr = a ^ 8'h01;           // later address change must not matter (R4)
      repeat (LAT) @(negedge clk);
      if (expect_drive) check(bus_drive == 1'b0, {tag, " R7 no drive before latency"}, bus_drive, 0);
      @(negedge clk);
      check(bus_drive == expect_drive, {tag, " R7 drive at latency"}, bus_drive, expect_drive);
      if (expect_drive) check(bus_out == exp, {tag, " data"}, bus_out, exp);
      repeat (ACT_RD - LAT - 2) @(negedge clk);
      drive(0, 1, 1, 1, a, 8'h00);
      @(negedge clk);
      check(bus_drive == expect_drive, {tag, " R7 drive held one edge"}, bus_drive, expect_drive);
      @(negedge clk);
      check(bus_drive == 1'b0, {tag, " R1 bus released"}, bus_drive, 0);
      repeat (2) @(negedge clk);
   endtask

   task automatic pulse_reset(string tag);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check(bus_drive == 1'b0, {tag, " bus off after reset"}, bus_drive, 0);
      check_flags(0, 0, 0, {tag, " R11 cleared by reset"});
      repeat (2) @(negedge clk);
   endtask

   task automatic test_reset;
      check(bus_drive == 1'b0, "R1 reset bus_drive", bus_drive, 0);
      check_flags(0, 0, 0, "R1 reset flags");
   endtask

   task automatic test_standby;
      do_write(0, 8'h05, 8'h50, 6, 4, 0);
      drive(1, 1, 1, 0, 8'h05, 8'h00);
      repeat (3) begin @(negedge clk); check(bus_drive == 1'b0, "R1 select A high", bus_drive, 0); end
      drive(0, 0, 1, 0, 8'h05, 8'h00);
      repeat (3) begin @(negedge clk); check(bus_drive == 1'b0, "R1 select B low", bus_drive, 0); end
      drive(1, 1, 0, 1, 8'h05, 8'hEE);
      repeat (3) @(negedge clk);
      drive(0, 0, 0, 1, 8'h05, 8'hEE);
      repeat (3) @(negedge clk);
      drive(0, 1, 1, 1, 8'h05, 8'h00);
      repeat (3) begin @(negedge clk); check(bus_drive == 1'b0, "R1 both strobes high", bus_drive, 0); end
      do_read(0, 8'h05, 8'h50, "R1 quiet writes ignored", 1);
   endtask

   task automatic test_we_write;
      do_write(0, 8'h41, 8'h3C, 6, 4, 0);
      do_write(0, 8'h40, 8'hA5, 6, 4, 1);
      do_read(0, 8'h40, 8'hA5, "R5 write strobe edge data", 1);
      do_read(0, 8'h41, 8'h3C, "R5 neighbour unchanged", 1);
   endtask

   task automatic test_ce_write;
      do_write(0, 8'h61, 8'h0F, 6, 4, 0);
      do_write(1, 8'h60, 8'hC3, 6, 4, 1);
      do_read(0, 8'h60, 8'hC3, "R6 select edge write", 1);
      do_read(0, 8'h61, 8'h0F, "R6 neighbour unchanged", 1);
   endtask

   task automatic test_select_reads;
      do_write(0, 8'h70, 8'h17, 6, 4, 0);
      do_read(1, 8'h70, 8'h17, "R2 select A fall read", 1);
      do_read(2, 8'h60, 8'hC3, "R3 select B rise read", 1);
      do_read(0, 8'h70, 8'h17, "R4 read strobe fall read", 1);
   endtask

   task automatic test_precharge;
      do_write(0, 8'h10, 8'h11, 6, 4, 0);
      do_write(0, 8'h20, 8'h21, 8, 1, 0);
      do_write(0, 8'h10, 8'h99, 8, 4, 0);   // one quiet sample only: rejected
      check_flags(1, 0, 0, "R8 short precharge");
      do_read(0, 8'h10, 8'h11, "R8 rejected write left data", 1);
      do_write(0, 8'h22, 8'h33, 8, 1, 0);
      do_read(0, 8'h20, 8'h21, "R8 rejected read no drive", 0);
      do_read(0, 8'h20, 8'h21, "R8 later read served", 1);
      check(err_precharge == 1'b1, "R11 precharge flag sticky", err_precharge, 1);
      pulse_reset("R8");
   endtask

   task automatic test_cycle;
      do_write(0, 8'h30, 8'h31, 4, 2, 0);
      do_write(0, 8'h30, 8'h77, 4, 4, 0);   // start-to-start 6 < 8
      check_flags(0, 1, 0, "R9 short cycle (R8 R10 limits met exactly)");
      do_read(0, 8'h30, 8'h31, "R9 rejected write left data", 1);
      pulse_reset("R9");
   endtask

   task automatic test_active;
      do_write(0, 8'h50, 8'h51, 2, 10, 0);
      check_flags(0, 0, 1, "R10 short active time");
      do_read(0, 8'h50, 8'h51, "R10 short access still written", 1);
      check(err_active == 1'b1, "R11 active flag sticky", err_active, 1);
      pulse_reset("R10");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      test_reset();
      repeat (2) @(negedge clk);
      test_standby();
      test_we_write();
      test_ce_write();
      test_select_reads();
      test_precharge();
      test_cycle();
      test_active();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 50000);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

endmodule